// File: doc/BRIEF.md
# Static RAM Expansion Card Bus Decoder

This block is the glue logic of a 1 MB static RAM expansion card that sits on a 68000-style asynchronous bus. It looks at address bits A16 to A23 together with the address strobe, and when the cycle falls inside the card's single 1 MB window it pulls one of sixteen active-low chip selects low. Each select enables a pair of byte-wide SRAMs, 32 KB each, so one select covers 64 KB. Bus address bits A1 to A15 go straight to the SRAM address pins and do not pass through this block. Bit A0 does not exist on the bus, so the byte lane is chosen by the data strobes.

All SRAMs share one output enable, which this block drives on reads. On writes it drives a separate write enable for the even (upper) lane and for the odd (lower) lane, each gated by its own data strobe. It also returns a data-transfer acknowledge a configurable number of clocks after a decoded strobe. The acknowledge is driven only during cycles that hit the card. A power-status input forces the whole card idle.

Top module: `sram_card_decoder`

## Requirements
- R1: The card responds only when addr_hi[7:4] (A23..A20) equals 4'b0001, which is the range 0x100000 to 0x1FFFFF. For any other value all cs_n stay high, oe_n and both write enables stay high, and dtack_en stays low.
- R2: In a decoded cycle, the value k of addr_hi[3:0] (A19..A16) drives cs_n[k] low and leaves every other cs_n bit high. At no time is more than one cs_n bit low.
- R3: cs_n, oe_n, we_hi_n, we_lo_n and dtack_en are active only while as_n is low. They return to idle combinationally in the same cycle in which as_n rises, with no clock edge needed.
- R4: While pwr_ok_n is high (power not good), all cs_n bits, oe_n, we_hi_n and we_lo_n are high and dtack_en is low, whatever the address and strobes.
- R5: In a decoded read (rw = 1), oe_n is low and both we_hi_n and we_lo_n are high, whatever the state of the data strobes.
- R6: In a decoded write (rw = 0), oe_n is high. we_hi_n is low exactly when uds_n is low, and we_lo_n is low exactly when lds_n is low, so a byte write touches only its own lane and a word write touches both.
- R7: dtack_n goes low after the ACK_DELAY-th rising clock edge at which a decoded cycle is active (default ACK_DELAY = 1). It stays low until as_n rises or the cycle stops being decoded, and it is high again in that same cycle.
- R8: dtack_en is high exactly while a decoded cycle is active, and dtack_n is high whenever dtack_en is low. The delay count starts again from zero for every new strobe. After reset dtack_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the acknowledge delay counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_hi | input | 8 | Bus address bits A23..A16 (bit 7 = A23) |
| as_n | input | 1 | Address strobe, active low |
| uds_n | input | 1 | Upper (even) byte data strobe, active low |
| lds_n | input | 1 | Lower (odd) byte data strobe, active low |
| rw | input | 1 | Transfer direction: 1 read, 0 write |
| pwr_ok_n | input | 1 | System power status, low when power is good |
| cs_n | output | 16 | Active-low chip select, one per SRAM pair |
| oe_n | output | 1 | Shared SRAM output enable, active low |
| we_hi_n | output | 1 | Upper-lane SRAM write enable, active low |
| we_lo_n | output | 1 | Lower-lane SRAM write enable, active low |
| dtack_n | output | 1 | Transfer acknowledge level, active low |
| dtack_en | output | 1 | Drive enable for the acknowledge line (low = released) |

## Verification
The bench sweeps all 256 values of A23..A16. A decoder that skips the upper bits would select chips in mirror windows, and one with a faulty one-hot stage would select two pairs or the wrong pair. Writes are run with each strobe alone and with both together, to catch lane enables that are swapped or tied together. Strobes are released and power is dropped in the middle of a cycle, to expose outputs that wait for a clock edge before letting go. Back-to-back strobes check that an acknowledge counter which fails to restart would acknowledge a new cycle early.

// File: rtl/sdec_pkg.sv
package sdec_pkg;
   // bus slice seen by the decoder: A16..A23
   localparam int ADDR_HI_W = 8;
   // per-lane strobe controls, active high internally
   typedef struct packed {
      logic oe;
      logic we_hi;
      logic we_lo;
   } lane_ctl_t;
endpackage

// File: rtl/sdec_window.sv
module sdec_window #(
   parameter int ADDR_HI_W = 8,
   parameter int SEL_W     = 4,
   parameter int TAG_W     = ADDR_HI_W - SEL_W,
   parameter logic [TAG_W-1:0] WIN_TAG = 1,
   localparam int NUM_SEL  = 1 << SEL_W
) (
   input  logic [ADDR_HI_W-1:0] addr_hi,
   input  logic                 as_n,
   input  logic                 pwr_ok_n,
   output logic                 cycle_active,
   output logic [NUM_SEL-1:0]   sel_oh
);
   logic [TAG_W-1:0] tag;
   logic [SEL_W-1:0] idx;
   logic             win_hit;

   generate
      if (ADDR_HI_W <= SEL_W) begin : g_bad_width
         $error("sdec_window: ADDR_HI_W must exceed SEL_W");
      end
   endgenerate

   assign tag     = addr_hi[ADDR_HI_W-1:SEL_W];
   assign idx     = addr_hi[SEL_W-1:0];
   assign win_hit = (tag == WIN_TAG);
   assign cycle_active = win_hit && !as_n && !pwr_ok_n;

   // one comparator per select line
   generate
      for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
         assign sel_oh[i] = cycle_active && (idx == SEL_W'(i));
      end
   endgenerate
endmodule

// File: rtl/sdec_lanes.sv
module sdec_lanes
   import sdec_pkg::*;
(
   input  logic      cycle_active,
   input  logic      rw,
   input  logic      uds_n,
   input  logic      lds_n,
   output lane_ctl_t ctl
);
   always_comb begin
      ctl.oe    = cycle_active && rw;
      ctl.we_hi = cycle_active && !rw && !uds_n;
      ctl.we_lo = cycle_active && !rw && !lds_n;
   end
endmodule

// File: rtl/sdec_ack.sv
module sdec_ack #(
   parameter int ACK_DELAY = 1,
   localparam int CNT_W = $clog2(ACK_DELAY + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cycle_active,
   output logic ack
);
   localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_DELAY);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (ACK_DELAY < 1) begin : g_bad_delay
         $error("sdec_ack: ACK_DELAY must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!cycle_active) begin
         cnt_q <= '0;
      end else if (cnt_q != ACK_LAST) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // gated so it drops the moment the strobe leaves
   assign ack = cycle_active && (cnt_q == ACK_LAST);
endmodule

// File: rtl/sram_card_decoder.sv
module sram_card_decoder
   import sdec_pkg::*;
#(
   parameter int SEL_W     = 4,
   parameter int ACK_DELAY = 1,
   parameter logic [ADDR_HI_W-SEL_W-1:0] WIN_TAG = 1,
   localparam int NUM_SEL  = 1 << SEL_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_HI_W-1:0] addr_hi,
   input  logic                 as_n,
   input  logic                 uds_n,
   input  logic                 lds_n,
   input  logic                 rw,
   input  logic                 pwr_ok_n,
   output logic [NUM_SEL-1:0]   cs_n,
   output logic                 oe_n,
   output logic                 we_hi_n,
   output logic                 we_lo_n,
   output logic                 dtack_n,
   output logic                 dtack_en
);
   logic               cycle_active;
   logic [NUM_SEL-1:0] sel_oh;
   lane_ctl_t          ctl;
   logic               ack;

   sdec_window #(
      .ADDR_HI_W (ADDR_HI_W),
      .SEL_W     (SEL_W),
      .WIN_TAG   (WIN_TAG)
   ) u_window (
      .addr_hi      (addr_hi),
      .as_n         (as_n),
      .pwr_ok_n     (pwr_ok_n),
      .cycle_active (cycle_active),
      .sel_oh       (sel_oh)
   );

   sdec_lanes u_lanes (
      .cycle_active (cycle_active),
      .rw           (rw),
      .uds_n        (uds_n),
      .lds_n        (lds_n),
      .ctl          (ctl)
   );

   sdec_ack #(.ACK_DELAY(ACK_DELAY)) u_ack (
      .clk          (clk),
      .rst_n        (rst_n),
      .cycle_active (cycle_active),
      .ack          (ack)
   );

   assign cs_n     = ~sel_oh;
   assign oe_n     = ~ctl.oe;
   assign we_hi_n  = ~ctl.we_hi;
   assign we_lo_n  = ~ctl.we_lo;
   assign dtack_n  = ~ack;
   assign dtack_en = cycle_active;

   AST_OUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_hi[ADDR_HI_W-1:SEL_W] != WIN_TAG) |-> (&cs_n && !dtack_en && oe_n)); // R1
   AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n)); // R2
   AST_STROBE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      as_n |-> (&cs_n && oe_n && we_hi_n && we_lo_n && dtack_n)); // R3
   AST_PWR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_ok_n |-> (&cs_n && oe_n && we_hi_n && we_lo_n && !dtack_en)); // R4
   AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> (we_hi_n && we_lo_n)); // R5
   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(as_n) |-> dtack_n); // R7
   AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dtack_n) |-> ($past(!as_n) && !as_n)); // R7
   AST_ACK_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      !dtack_en |-> dtack_n); // R8
endmodule

// File: tb/sram_card_decoder_bench.sv
`timescale 1ns/1ps
module sram_card_decoder_bench;
   localparam int D = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  addr_hi = 8'h00;
   logic        as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1;
   logic        pwr_ok_n = 1'b0;
   logic [15:0] cs_n;
   logic        oe_n, we_hi_n, we_lo_n, dtack_n, dtack_en;

   int checks = 0;
   int errors = 0;
   int ref_cnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   sram_card_decoder #(.ACK_DELAY(D)) u_sram_card_decoder (
      .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .as_n(as_n),
      .uds_n(uds_n), .lds_n(lds_n), .rw(rw), .pwr_ok_n(pwr_ok_n),
      .cs_n(cs_n), .oe_n(oe_n), .we_hi_n(we_hi_n), .we_lo_n(we_lo_n),
      .dtack_n(dtack_n), .dtack_en(dtack_en));

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic bit ref_active();
      return (addr_hi[7:4] == 4'd1) && !as_n && !pwr_ok_n;
   endfunction

   // cycle-accurate reference, compared every clock
   always begin
      @(posedge clk);
      if (!rst_n || !ref_active()) ref_cnt = 0;
      else if (ref_cnt < D) ref_cnt++;
      #1;
      if (rst_n) begin
         automatic bit a = ref_active();
         automatic logic [15:0] ecs = a ? ~(16'h1 << addr_hi[3:0]) : 16'hFFFF;
         chk(cs_n == ecs, "R1/R2", "cs_n", cs_n, ecs);
         chk($countones(~cs_n) <= 1, "R2", "select count", $countones(~cs_n), 1);
         chk(oe_n == !(a && rw), "R5", "oe_n", oe_n, !(a && rw));
         chk(we_hi_n == !(a && !rw && !uds_n), "R6", "we_hi_n", we_hi_n, !(a && !rw && !uds_n));
         chk(we_lo_n == !(a && !rw && !lds_n), "R6", "we_lo_n", we_lo_n, !(a && !rw && !lds_n));
         chk(dtack_en == a, "R8", "dtack_en", dtack_en, a);
         chk(dtack_n == !(a && ref_cnt >= D), "R7", "dtack_n", dtack_n, !(a && ref_cnt >= D));
      end
   end

   task automatic cyc(input logic [7:0] ad, input logic r, input logic u,
                      input logic l, input int hold);
      @(negedge clk);
      addr_hi = ad; rw = r; as_n = 1'b0; uds_n = u; lds_n = l;
      repeat (hold) @(negedge clk);
      as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
      #0.5;
      chk(&cs_n && oe_n && we_hi_n && we_lo_n && dtack_n && !dtack_en, "R3",
          "idle after strobe rise", {cs_n, oe_n, dtack_n}, 18'h3FFFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(dtack_n == 1'b1 && &cs_n, "R8", "reset state", {cs_n, dtack_n}, 17'h1FFFF);
      rst_n = 1'b1;
      // R1 R2: full sweep of A23..A16, read cycles
      for (int v = 0; v < 256; v++) cyc(8'(v), 1'b1, 1'b0, 1'b0, D + 2);
      // R6: byte and word writes
      cyc(8'h13, 1'b0, 1'b0, 1'b1, D + 1);
      cyc(8'h1A, 1'b0, 1'b1, 1'b0, D + 1);
      cyc(8'h1F, 1'b0, 1'b0, 1'b0, D + 1);
      // R5: byte read with one strobe
      cyc(8'h10, 1'b1, 1'b1, 1'b0, D + 1);
      // R8: short strobes back to back, counter must restart
      cyc(8'h15, 1'b1, 1'b0, 1'b0, 1);
      cyc(8'h15, 1'b1, 1'b0, 1'b0, 1);
      cyc(8'h16, 1'b1, 1'b0, 1'b0, D + 3);
      // R4: power drop in mid cycle
      @(negedge clk);
      addr_hi = 8'h1C; rw = 1'b0; as_n = 1'b0; uds_n = 1'b0; lds_n = 1'b0;
      repeat (D + 1) @(negedge clk);
      pwr_ok_n = 1'b1;
      #0.5;
      chk(&cs_n && we_hi_n && we_lo_n && oe_n && !dtack_en && dtack_n, "R4",
          "power fail idle", {cs_n, dtack_en}, 17'h1FFFE);
      repeat (3) @(negedge clk);
      pwr_ok_n = 1'b0;
      repeat (D + 2) @(negedge clk);
      as_n = 1'b1; uds_n = 1'b1; lds_n = 1'b1;
      repeat (3) @(negedge clk);
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule